// File: doc/BRIEF.md
# Torus Adaptive Route Selector

This block decides, for the header of a packet sitting at one router of a two-dimensional torus, which output direction the packet takes next and on which virtual channel it travels. Each dimension holds up to 16 nodes. The inputs are:

- the router's own coordinates and the destination coordinates;
- one sign bit per dimension, which says which way around the ring the packet travels;
- the adaptive-allowed and IO header flags;
- the port the packet arrived on;
- one congestion flag per network output;
- two swap vectors, loaded at boot, that reshape the deadlock-free channel assignment per dimension.

Routing stays inside the minimal rectangle. At most two outputs are candidates: the one that keeps the packet moving in its current dimension, and the one that turns it. The straight route is preferred when it is free. The escape channels VC0 and VC1 form a deadlock-free network. X is the primary axis and may use them on any hop. Y is the secondary axis and may use them only once the X coordinate already matches the destination.

The decision is a pure function of the present header and router state, with no memory of the route taken so far. A packet that travelled in an escape channel returns to the adaptive channel as soon as its chosen output is free. One register stage holds the result.

Top module: `torus_route_sel`

## Requirements
- R1: A header presented with `in_valid` high produces `out_valid` high with its result exactly one clock later. A cycle with `in_valid` low gives `out_valid` low one clock later, and the result fields keep their previous values.
- R2: While reset is asserted, `out_valid`, `out_deliver`, `out_port` and `out_vc` are all zero.
- R3: When the local X and Y coordinates both equal the destination, `out_deliver` is 1, `out_port` is 4 (local), `out_vc` is 0, and congestion flags are ignored.
- R4: Port codes are 0 east, 1 west, 2 north and 3 south, and bit k of `cong` is the congestion flag of port k. The X candidate is west when `neg_x` is set and east otherwise. The Y candidate is south when `neg_y` is set and north otherwise. When only one dimension has distance left, its candidate is chosen whatever the congestion. For an unrestricted packet the VC is adaptive if that port is free and the escape VC if it is congested.
- R5: For an unrestricted packet with distance left in both dimensions, the straight dimension is Y when `in_port` is 2 or 3 and X for every other value. If the straight candidate is uncongested, it is chosen with VC code 0 (adaptive).
- R6: When the straight candidate is congested and the turning candidate is free, the turning candidate is chosen with VC code 0.
- R7: When both candidates are congested, the X candidate is chosen with the escape VC.
- R8: A restricted packet (`io_pkt` set or `adapt_ok` clear) always uses the escape VC and routes X first: the X candidate while X distance remains, then the Y candidate. Congestion is ignored.
- R9: VC codes are 0 adaptive, 1 VC0 and 2 VC1. The escape VC for a hop in a dimension is VC0 when the current coordinate in that dimension is below the destination and VC1 when it is above. The choice is inverted when bit [current coordinate] of that dimension's swap vector is set.
- R10: A north or south hop carries a non-zero VC only when `cur_x` equals `dst_x`, and `out_vc` never takes code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Header present this cycle |
| cur_x | input | 4 | Local X coordinate |
| cur_y | input | 4 | Local Y coordinate |
| dst_x | input | 4 | Destination X coordinate |
| dst_y | input | 4 | Destination Y coordinate |
| neg_x | input | 1 | Travel in negative X direction |
| neg_y | input | 1 | Travel in negative Y direction |
| adapt_ok | input | 1 | Header permits adaptive channel |
| io_pkt | input | 1 | Header marks an IO packet |
| in_port | input | 3 | Arrival port code |
| cong | input | 4 | Per-output congestion flags |
| esc_swap_x | input | 16 | Boot-time escape VC swap bits, X ring |
| esc_swap_y | input | 16 | Boot-time escape VC swap bits, Y ring |
| out_valid | output | 1 | Result valid |
| out_deliver | output | 1 | Packet has arrived at this node |
| out_port | output | 3 | Chosen output port |
| out_vc | output | 2 | Chosen virtual channel code |

## Verification
Every result (port, VC and local-delivery flag) is due at the first rising edge after the header is applied, because one register sits between inputs and outputs. The bench drives each header on a falling edge and compares all outputs on the next falling edge, half a period after that register has loaded. Idle cycles are checked in the same slot to confirm that valid drops while the held fields do not move. Reset values are read on a falling edge while reset is still low.

// File: rtl/torus_route_pkg.sv
package torus_route_pkg;

    typedef enum logic [2:0] {
        PORT_EAST  = 3'd0,
        PORT_WEST  = 3'd1,
        PORT_NORTH = 3'd2,
        PORT_SOUTH = 3'd3,
        PORT_LOCAL = 3'd4
    } port_e;

    typedef enum logic [1:0] {
        VC_ADAPT = 2'd0,
        VC_ESC0  = 2'd1,
        VC_ESC1  = 2'd2,
        VC_BAD   = 2'd3
    } vc_e;

    typedef struct packed {
        logic  valid;
        logic  deliver;
        port_e port;
        vc_e   vc;
    } route_res_t;

endpackage

// File: rtl/route_dim.sv
// Per-dimension candidate: remaining-distance flag and signed output port.
module route_dim
    import torus_route_pkg::*;
#(
    parameter int COORD_W = 4,
    parameter bit IS_X    = 1'b1
) (
    input  logic [COORD_W-1:0] cur,
    input  logic [COORD_W-1:0] dst,
    input  logic               neg,
    output logic               done,
    output port_e              port
);
    always_comb begin
        done = (cur == dst);
        if (IS_X) begin
            port = neg ? PORT_WEST : PORT_EAST;
        end else begin
            port = neg ? PORT_SOUTH : PORT_NORTH;
        end
    end
endmodule

// File: rtl/route_escvc.sv
// Escape channel for one dimension: index ordering, optionally swapped per node.
module route_escvc
    import torus_route_pkg::*;
#(
    parameter int COORD_W = 4,
    localparam int NODES  = 1 << COORD_W
) (
    input  logic [COORD_W-1:0] cur,
    input  logic [COORD_W-1:0] dst,
    input  logic [NODES-1:0]   swap_map,
    output vc_e                esc_vc
);
    logic above;
    always_comb begin
        above  = (cur > dst);
        esc_vc = (above ^ swap_map[cur]) ? VC_ESC1 : VC_ESC0;
    end
endmodule

// File: rtl/torus_route_sel.sv
module torus_route_sel
    import torus_route_pkg::*;
#(
    parameter int COORD_W = 4,
    localparam int NODES  = 1 << COORD_W,
    localparam int DIMS   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    input  logic               neg_x,
    input  logic               neg_y,
    input  logic               adapt_ok,
    input  logic               io_pkt,
    input  logic [2:0]         in_port,
    input  logic [3:0]         cong,
    input  logic [NODES-1:0]   esc_swap_x,
    input  logic [NODES-1:0]   esc_swap_y,
    output logic               out_valid,
    output logic               out_deliver,
    output logic [2:0]         out_port,
    output logic [1:0]         out_vc
);
    logic [COORD_W-1:0] cur_c [DIMS];
    logic [COORD_W-1:0] dst_c [DIMS];
    logic [NODES-1:0]   swap_c [DIMS];
    logic               neg_c [DIMS];
    logic               done_c [DIMS];
    port_e              port_c [DIMS];
    vc_e                esc_c [DIMS];

    assign cur_c[0]  = cur_x;
    assign cur_c[1]  = cur_y;
    assign dst_c[0]  = dst_x;
    assign dst_c[1]  = dst_y;
    assign neg_c[0]  = neg_x;
    assign neg_c[1]  = neg_y;
    assign swap_c[0] = esc_swap_x;
    assign swap_c[1] = esc_swap_y;

    for (genvar g = 0; g < DIMS; g++) begin : g_dim
        route_dim #(.COORD_W(COORD_W), .IS_X(g == 0)) dim_i (
            .cur  (cur_c[g]),
            .dst  (dst_c[g]),
            .neg  (neg_c[g]),
            .done (done_c[g]),
            .port (port_c[g])
        );
        route_escvc #(.COORD_W(COORD_W)) esc_i (
            .cur      (cur_c[g]),
            .dst      (dst_c[g]),
            .swap_map (swap_c[g]),
            .esc_vc   (esc_c[g])
        );
    end

    route_res_t res_d, res_q;
    logic       restricted;
    logic       straight_y;
    logic       pick;
    logic       use_esc;

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        restricted  = io_pkt | ~adapt_ok;
        straight_y  = (in_port == 3'd2) || (in_port == 3'd3);
        pick        = 1'b0;
        use_esc     = 1'b0;
        if (done_c[0] && done_c[1]) begin
            res_d.deliver = 1'b1;
            res_d.port    = PORT_LOCAL;
            res_d.vc      = VC_ADAPT;
        end else begin
            if (restricted) begin
                pick    = done_c[0];
                use_esc = 1'b1;
            end else if (done_c[0]) begin
                pick    = 1'b1;
                use_esc = cong[port_c[1][1:0]];
            end else if (done_c[1]) begin
                pick    = 1'b0;
                use_esc = cong[port_c[0][1:0]];
            end else if (!cong[port_c[straight_y][1:0]]) begin
                pick    = straight_y;
            end else if (!cong[port_c[~straight_y][1:0]]) begin
                pick    = ~straight_y;
            end else begin
                pick    = 1'b0;
                use_esc = 1'b1;
            end
            res_d.deliver = 1'b0;
            res_d.port    = port_c[pick];
            res_d.vc      = use_esc ? esc_c[pick] : VC_ADAPT;
        end
        if (!in_valid) begin
            res_d         = res_q;
            res_d.valid   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '{valid: 1'b0, deliver: 1'b0, port: PORT_EAST, vc: VC_ADAPT};
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid   = res_q.valid;
    assign out_deliver = res_q.deliver;
    assign out_port    = res_q.port;
    assign out_vc      = res_q.vc;
endmodule

// File: rtl/torus_route_sel_chk.sv
module torus_route_sel_chk #(
    parameter int COORD_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [COORD_W-1:0] cur_x,
    input logic [COORD_W-1:0] cur_y,
    input logic [COORD_W-1:0] dst_x,
    input logic [COORD_W-1:0] dst_y,
    input logic               adapt_ok,
    input logic               io_pkt,
    input logic               out_valid,
    input logic               out_deliver,
    input logic [2:0]         out_port,
    input logic [1:0]         out_vc
);
    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_port) && $stable(out_vc)));

    p_reset_r2: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && !out_deliver && out_vc == 2'd0));

    p_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cur_x == dst_x && cur_y == dst_y)
        |=> (out_deliver && out_port == 3'd4 && out_vc == 2'd0));

    p_restricted_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (io_pkt || !adapt_ok) && !(cur_x == dst_x && cur_y == dst_y))
        |=> (out_vc != 2'd0 && !out_deliver));

    p_secondary_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cur_x != dst_x)
        |=> !((out_port == 3'd2 || out_port == 3'd3) && out_vc != 2'd0));

    p_vc_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_vc != 2'd3);
endmodule

bind torus_route_sel torus_route_sel_chk #(.COORD_W(COORD_W)) chk_i (.*);

// File: tb/torus_route_sel_tb.sv
module torus_route_sel_tb_top;
    localparam int CW = 4;
    localparam int NN = 1 << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [CW-1:0] cur_x = '0, cur_y = '0, dst_x = '0, dst_y = '0;
    logic          neg_x = 1'b0, neg_y = 1'b0, adapt_ok = 1'b1, io_pkt = 1'b0;
    logic [2:0]    in_port = 3'd4;
    logic [3:0]    cong = '0;
    logic [NN-1:0] esc_swap_x = '0, esc_swap_y = '0;
    logic          out_valid, out_deliver;
    logic [2:0]    out_port;
    logic [1:0]    out_vc;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    torus_route_sel #(.COORD_W(CW)) dut_i (.*);

    function automatic logic [1:0] esc_of(input logic [CW-1:0] c, input logic [CW-1:0] d,
                                          input logic [NN-1:0] m);
        return ((c > d) ^ m[c]) ? 2'd2 : 2'd1;
    endfunction

    // expected {deliver, port[2:0], vc[1:0]}
    function automatic logic [5:0] model();
        logic [2:0] px, py, p;
        logic xd, yd, sy, useesc, dimy;
        px = neg_x ? 3'd1 : 3'd0;
        py = neg_y ? 3'd3 : 3'd2;
        xd = (cur_x == dst_x);
        yd = (cur_y == dst_y);
        if (xd && yd) return {1'b1, 3'd4, 2'd0};
        sy = (in_port == 3'd2 || in_port == 3'd3);
        useesc = 1'b0;
        if (io_pkt || !adapt_ok) begin
            dimy = xd; useesc = 1'b1;
        end else if (xd) begin
            dimy = 1'b1; useesc = cong[py[1:0]];
        end else if (yd) begin
            dimy = 1'b0; useesc = cong[px[1:0]];
        end else begin
            p = sy ? py : px;
            if (!cong[p[1:0]]) dimy = sy;
            else begin
                p = sy ? px : py;
                if (!cong[p[1:0]]) dimy = ~sy;
                else begin dimy = 1'b0; useesc = 1'b1; end
            end
        end
        p = dimy ? py : px;
        if (!useesc) return {1'b0, p, 2'd0};
        return {1'b0, p, dimy ? esc_of(cur_y, dst_y, esc_swap_y) : esc_of(cur_x, dst_x, esc_swap_x)};
    endfunction

    task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got deliver/port/vc=%b/%0d/%0d expected %b/%0d/%0d",
                     tag, act[5], act[4:2], act[1:0], exp[5], exp[4:2], exp[1:0]);
        end
    endtask

    task automatic run(input string tag);
        logic [5:0] e;
        @(negedge clk);
        in_valid = 1'b1;
        e = model();
        @(negedge clk);
        in_valid = 1'b0;
        tests++;
        if (out_valid !== 1'b1) begin
            fails++;
            $display("FAIL R1: out_valid=%b expected 1", out_valid);
        end
        chk(tag, {out_deliver, out_port, out_vc}, e);
    endtask

    task automatic set_hdr(input int cx, input int cy, input int dx, input int dy,
                           input logic nx, input logic ny, input logic ad, input logic io,
                           input int ip, input logic [3:0] cg);
        cur_x = CW'(cx); cur_y = CW'(cy); dst_x = CW'(dx); dst_y = CW'(dy);
        neg_x = nx; neg_y = ny; adapt_ok = ad; io_pkt = io; in_port = 3'(ip); cong = cg;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        tests++;
        if ({out_valid, out_deliver, out_port, out_vc} !== 7'd0) begin
            fails++;
            $display("FAIL R2: outputs=%b expected 0", {out_valid, out_deliver, out_port, out_vc});
        end
        rst_n = 1'b1;

        // R3 local delivery ignores congestion
        set_hdr(5, 9, 5, 9, 0, 0, 1, 0, 0, 4'hF); run("R3");
        // R4 only Y remaining, free -> adaptive; congested -> escape
        set_hdr(3, 2, 3, 7, 0, 0, 1, 0, 0, 4'h0); run("R4");
        set_hdr(3, 7, 3, 2, 0, 1, 1, 0, 0, 4'h8); run("R4");
        // R4 only X remaining, congested west -> escape VC0 (3<9)
        set_hdr(3, 4, 9, 4, 1, 0, 1, 0, 0, 4'h2); run("R4");
        // R5 straight from north input, Y free -> Y adaptive
        set_hdr(1, 1, 6, 6, 0, 0, 1, 0, 2, 4'h1); run("R5");
        // R5 straight from local input is X
        set_hdr(1, 1, 6, 6, 0, 0, 1, 0, 4, 4'h0); run("R5");
        // R6 straight X congested, Y free -> turn
        set_hdr(1, 1, 6, 6, 0, 0, 1, 0, 1, 4'h1); run("R6");
        // R7 both congested -> X escape
        set_hdr(8, 1, 2, 6, 1, 0, 1, 0, 3, 4'hF); run("R7");
        // R8 restricted: IO with free ports still escape, X first
        set_hdr(2, 2, 9, 9, 0, 0, 1, 1, 2, 4'h0); run("R8");
        set_hdr(9, 2, 9, 11, 0, 0, 0, 0, 0, 4'h0); run("R8");
        // R9 swap bit inverts escape choice
        esc_swap_x = 16'h0004;
        set_hdr(2, 5, 9, 5, 0, 0, 0, 0, 0, 4'h0); run("R9");
        esc_swap_x = '0;
        set_hdr(12, 5, 4, 5, 1, 0, 0, 0, 0, 4'h0); run("R9");
        // R1 idle hold
        begin
            logic [2:0] hp;
            logic [1:0] hv;
            hp = out_port; hv = out_vc;
            set_hdr(0, 0, 15, 15, 0, 0, 1, 0, 0, 4'h0);
            @(negedge clk);
            tests++;
            if (out_valid !== 1'b0 || out_port !== hp || out_vc !== hv) begin
                fails++;
                $display("FAIL R1: idle valid/port/vc=%b/%0d/%0d expected 0/%0d/%0d",
                         out_valid, out_port, out_vc, hp, hv);
            end
        end
        // random mix, R10 checked alongside
        for (int i = 0; i < 1500; i++) begin
            set_hdr(int'($urandom_range(15)), int'($urandom_range(15)),
                    int'($urandom_range(15)), int'($urandom_range(15)),
                    1'($urandom), 1'($urandom), ($urandom_range(3) != 0), ($urandom_range(5) == 0),
                    int'($urandom_range(7)), 4'($urandom));
            if ($urandom_range(3) == 0) begin
                esc_swap_x = 16'($urandom);
                esc_swap_y = 16'($urandom);
            end
            if ($urandom_range(4) == 0) dst_x = cur_x;
            if ($urandom_range(4) == 0) dst_y = cur_y;
            run("R4-R9 random");
            tests++;
            if (out_vc == 2'd3 || ((out_port == 3'd2 || out_port == 3'd3) && out_vc != 2'd0 && cur_x != dst_x)) begin
                fails++;
                $display("FAIL R10: port/vc=%0d/%0d cur_x=%0d dst_x=%0d expected legal escape use",
                         out_port, out_vc, cur_x, dst_x);
            end
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule